// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block keeps the control and status word of a single-precision floating-point unit. The word holds two fields. The low five bits are the accrued exception flags. Bits 7:5 hold the dynamic rounding mode. Software reads and writes the word through a register-style port. The retire stage of the core reports each finished floating-point instruction on a second port. That report carries a valid strobe, a flag-update enable, an operation class code and the five exception flags the instruction produced.

Only some operation classes may touch the flags. Arithmetic, min/max, float-to-integer conversion and compares replace the flag field with the reported vector. Sign injection, classify, raw moves, loads, stores and integer-to-float conversion leave it unchanged. A third port resolves a rounding-mode field taken from an instruction. Codes 0 to 6 are used as given. Code 7 selects the dynamic mode stored in the word. The port returns the effective mode one cycle later, together with an illegal-instruction indication when that mode is a reserved code.

Top module: `fpstat_unit`

## Requirements
- R1: After a synchronous reset, `csr_rdata`, `rm_eff` and `rm_illegal` are all zero.
- R2: A software write (`csr_we`=1) stores `csr_wdata[7:0]`. From the next cycle `csr_rdata` shows that byte in bits 7:0, and bits 31:8 always read zero whatever was written.
- R3: A flag update replaces bits 4:0 with `ret_flags` and keeps bits 7:5 unchanged. The new value is visible on `csr_rdata` the cycle after the retire report.
- R4: A flag update happens when `ret_valid`=1, `ret_flag_en`=1 and `ret_cls` is one of the flag-producing classes. Those classes are coded 0 fused multiply-add, 1 add/subtract, 2 multiply, 3 divide, 4 square root, 5 min/max, 6 float-to-integer and 7 compare.
- R5: Class codes 8 to 15 cover sign injection (8), classify (9), raw move (10), load (11), store (12), integer-to-float (13) and two unused codes (14, 15). A report with one of these codes, or with `ret_valid`=0, or with `ret_flag_en`=0, leaves `csr_rdata` unchanged.
- R6: When a software write and a flag update arrive in the same cycle, the write alone takes effect and the flag update is discarded.
- R7: For `rm_in` values 0 to 6, `rm_eff` equals `rm_in` one cycle later.
- R8: For `rm_in`=7, `rm_eff` one cycle later equals bits 7:5 of the word as they stood before that clock edge.
- R9: `rm_illegal` is 1 exactly when the registered `rm_eff` is 5 or 6. An effective mode of 7 is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Software write strobe |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Current register word (registered) |
| ret_valid | input | 1 | Retire report valid |
| ret_flag_en | input | 1 | Retire report may update flags |
| ret_cls | input | 4 | Operation class code of the retiring instruction |
| ret_flags | input | 5 | Exception flags from the retiring instruction |
| rm_in | input | 3 | Rounding-mode field of the instruction being resolved |
| rm_eff | output | 3 | Effective rounding mode (registered) |
| rm_illegal | output | 1 | Effective mode is reserved (registered) |

## Verification
The stored word is the only state that outlives one cycle. Any corruption of it shows on `csr_rdata` on the cycle after the offending edge. It also shows on `rm_eff` one cycle after any `rm_in` of 7, so a bad dynamic-mode field is seen through two separate paths. A wrong class filter or a lost write priority leaves a flag byte that differs from the expected one at the next read. Reserved-mode decoding errors appear on `rm_illegal` in the same cycle as the matching `rm_eff`.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;
  localparam int CTRL_W = FLAG_W + RM_W;
  localparam int CLS_W  = 4;
  localparam int WORD_W = 32;

  typedef enum logic [CLS_W-1:0] {
    CLS_FMA   = 4'd0,
    CLS_ADD   = 4'd1,
    CLS_MUL   = 4'd2,
    CLS_DIV   = 4'd3,
    CLS_SQRT  = 4'd4,
    CLS_MNMX  = 4'd5,
    CLS_F2I   = 4'd6,
    CLS_CMP   = 4'd7,
    CLS_SGN   = 4'd8,
    CLS_CLASS = 4'd9,
    CLS_MOVE  = 4'd10,
    CLS_LOAD  = 4'd11,
    CLS_STORE = 4'd12,
    CLS_I2F   = 4'd13,
    CLS_RSV0  = 4'd14,
    CLS_RSV1  = 4'd15
  } op_cls_e;

  function automatic logic cls_sets_flags(op_cls_e c);
    case (c)
      CLS_FMA, CLS_ADD, CLS_MUL, CLS_DIV,
      CLS_SQRT, CLS_MNMX, CLS_F2I, CLS_CMP: return 1'b1;
      default:                              return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fpstat_flagsel.sv
module fpstat_flagsel #(
  parameter int CLS_W = fpstat_pkg::CLS_W
) (
  input  logic             valid,
  input  logic             flag_en,
  input  logic [CLS_W-1:0] cls,
  output logic             upd
);
  import fpstat_pkg::*;
  op_cls_e cls_e;
  always_comb begin
    cls_e = op_cls_e'(cls);
    upd   = valid && flag_en && cls_sets_flags(cls_e);
  end
endmodule

// File: rtl/fpstat_store.sv
module fpstat_store #(
  parameter int WORD_W = fpstat_pkg::WORD_W,
  parameter int FLAG_W = fpstat_pkg::FLAG_W,
  parameter int RM_W   = fpstat_pkg::RM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              upd,
  input  logic [FLAG_W-1:0] flags,
  output logic [WORD_W-1:0] word,
  output logic [RM_W-1:0]   dyn_rm
);
  localparam int CTRL_W = FLAG_W + RM_W;
  localparam int PAD_W  = WORD_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              unused_hi;

  assign unused_hi = ^wr_data[WORD_W-1:CTRL_W];

  // software write wins; a coincident flag update is dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= wr_data[CTRL_W-1:0];
    end else if (upd) begin
      ctrl_q[FLAG_W-1:0] <= flags;
    end
  end

  assign word   = {{PAD_W{1'b0}}, ctrl_q};
  assign dyn_rm = ctrl_q[CTRL_W-1:FLAG_W];
endmodule

// File: rtl/fpstat_rmres.sv
module fpstat_rmres #(
  parameter int RM_W   = fpstat_pkg::RM_W,
  parameter int RSV_LO = 5,
  parameter int RSV_HI = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RM_W-1:0] rm_in,
  input  logic [RM_W-1:0] dyn_rm,
  output logic [RM_W-1:0] rm_eff,
  output logic            rm_ill
);
  localparam logic [RM_W-1:0] DYN_CODE = {RM_W{1'b1}};
  localparam logic [RM_W-1:0] LO = RSV_LO[RM_W-1:0];
  localparam logic [RM_W-1:0] HI = RSV_HI[RM_W-1:0];

  logic [RM_W-1:0] sel;
  logic            ill;

  always_comb begin
    sel = (rm_in == DYN_CODE) ? dyn_rm : rm_in;
    ill = (sel >= LO) && (sel <= HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rm_eff <= '0;
      rm_ill <= 1'b0;
    end else begin
      rm_eff <= sel;
      rm_ill <= ill;
    end
  end
endmodule

// File: rtl/fpstat_unit.sv
module fpstat_unit #(
  parameter int WORD_W = fpstat_pkg::WORD_W,
  parameter int FLAG_W = fpstat_pkg::FLAG_W,
  parameter int RM_W   = fpstat_pkg::RM_W,
  parameter int CLS_W  = fpstat_pkg::CLS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  input  logic              ret_valid,
  input  logic              ret_flag_en,
  input  logic [CLS_W-1:0]  ret_cls,
  input  logic [FLAG_W-1:0] ret_flags,
  input  logic [RM_W-1:0]   rm_in,
  output logic [RM_W-1:0]   rm_eff,
  output logic              rm_illegal
);
  logic            upd;
  logic [RM_W-1:0] dyn_rm;

  fpstat_flagsel #(.CLS_W(CLS_W)) u_sel (
    .valid   (ret_valid),
    .flag_en (ret_flag_en),
    .cls     (ret_cls),
    .upd     (upd)
  );

  fpstat_store #(.WORD_W(WORD_W), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (csr_we),
    .wr_data (csr_wdata),
    .upd     (upd),
    .flags   (ret_flags),
    .word    (csr_rdata),
    .dyn_rm  (dyn_rm)
  );

  fpstat_rmres #(.RM_W(RM_W)) u_rm (
    .clk    (clk),
    .rst    (rst),
    .rm_in  (rm_in),
    .dyn_rm (dyn_rm),
    .rm_eff (rm_eff),
    .rm_ill (rm_illegal)
  );
endmodule

// File: rtl/fpstat_unit_chk.sv
module fpstat_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        csr_we,
  input logic [31:0] csr_wdata,
  input logic [31:0] csr_rdata,
  input logic        ret_valid,
  input logic        ret_flag_en,
  input logic [3:0]  ret_cls,
  input logic [4:0]  ret_flags,
  input logic [2:0]  rm_in,
  input logic [2:0]  rm_eff,
  input logic        rm_illegal
);
  // R2: write lands next cycle, upper bits zero
  a_r2_write: assert property (@(posedge clk) disable iff (rst)
    csr_we |=> csr_rdata == {24'h0, $past(csr_wdata[7:0])});

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[31:8] == 24'h0);

  // R3, R4: update from a flag-producing class
  a_r3_flag_replace: assert property (@(posedge clk) disable iff (rst)
    (!csr_we && ret_valid && ret_flag_en && ret_cls < 4'd8) |=>
      (csr_rdata[4:0] == $past(ret_flags) && csr_rdata[7:5] == $past(csr_rdata[7:5])));

  // R5: other reports leave the word alone
  a_r5_no_update: assert property (@(posedge clk) disable iff (rst)
    (!csr_we && !(ret_valid && ret_flag_en && ret_cls < 4'd8)) |=> $stable(csr_rdata));

  // R7
  a_r7_static_rm: assert property (@(posedge clk) disable iff (rst)
    (rm_in != 3'd7) |=> rm_eff == $past(rm_in));

  // R8
  a_r8_dynamic_rm: assert property (@(posedge clk) disable iff (rst)
    (rm_in == 3'd7) |=> rm_eff == $past(csr_rdata[7:5]));

  // R9
  a_r9_illegal: assert property (@(posedge clk) disable iff (rst)
    rm_illegal == (rm_eff == 3'd5 || rm_eff == 3'd6));
endmodule

bind fpstat_unit fpstat_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_we      (csr_we),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .ret_valid   (ret_valid),
  .ret_flag_en (ret_flag_en),
  .ret_cls     (ret_cls),
  .ret_flags   (ret_flags),
  .rm_in       (rm_in),
  .rm_eff      (rm_eff),
  .rm_illegal  (rm_illegal)
);

// File: tb/fpstat_unit_tb_top.sv
`timescale 1ns/1ps
module fpstat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        ret_valid = 1'b0;
  logic        ret_flag_en = 1'b0;
  logic [3:0]  ret_cls = '0;
  logic [4:0]  ret_flags = '0;
  logic [2:0]  rm_in = '0;
  logic [2:0]  rm_eff;
  logic        rm_illegal;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] exp_q;

  always #5 clk = ~clk;

  fpstat_unit dut_i (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .ret_valid(ret_valid), .ret_flag_en(ret_flag_en),
    .ret_cls(ret_cls), .ret_flags(ret_flags), .rm_in(rm_in),
    .rm_eff(rm_eff), .rm_illegal(rm_illegal)
  );

  // {cls[3:0], valid, flag_en, flags[4:0]}
  localparam int NV = 13;
  localparam logic [10:0] VEC [NV] = '{
    {4'd0,  1'b1, 1'b1, 5'h01},
    {4'd1,  1'b1, 1'b1, 5'h1f},
    {4'd2,  1'b1, 1'b1, 5'h02},
    {4'd3,  1'b1, 1'b1, 5'h04},
    {4'd4,  1'b1, 1'b1, 5'h08},
    {4'd5,  1'b1, 1'b1, 5'h10},
    {4'd6,  1'b1, 1'b1, 5'h03},
    {4'd7,  1'b1, 1'b1, 5'h05},
    {4'd8,  1'b1, 1'b1, 5'h1f},
    {4'd13, 1'b1, 1'b1, 5'h0a},
    {4'd0,  1'b0, 1'b1, 5'h1e},
    {4'd0,  1'b1, 1'b0, 5'h1e},
    {4'd15, 1'b1, 1'b1, 5'h11}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    csr_we = 1'b1; csr_wdata = d;
    step();
    csr_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", csr_rdata, 32'h0);
    chk("R1 rm_eff", {29'h0, rm_eff}, 32'h0);
    chk("R1 rm_illegal", {31'h0, rm_illegal}, 32'h0);

    // R2 full write, upper bits ignored
    wr(32'hffff_ffff);
    chk("R2 upper ignored", csr_rdata, 32'h0000_00ff);
    wr(32'h1234_56a0);
    exp_q = 8'ha0;
    chk("R2 write", csr_rdata, {24'h0, exp_q});

    // R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] c;
      logic v, e, hit;
      logic [4:0] f;
      {c, v, e, f} = VEC[i];
      ret_cls = c; ret_valid = v; ret_flag_en = e; ret_flags = f;
      hit = v && e && (c < 4'd8);
      step();
      ret_valid = 1'b0; ret_flag_en = 1'b0;
      if (hit) begin
        exp_q[4:0] = f;
        chk("R3 R4 flag update", csr_rdata, {24'h0, exp_q});
      end else begin
        chk("R5 no update", csr_rdata, {24'h0, exp_q});
      end
    end

    // R6 write priority over a coincident update
    ret_valid = 1'b1; ret_flag_en = 1'b1; ret_cls = 4'd1; ret_flags = 5'h1f;
    wr(32'h0000_0040);
    ret_valid = 1'b0; ret_flag_en = 1'b0;
    exp_q = 8'h40;
    chk("R6 write wins", csr_rdata, {24'h0, exp_q});

    // R7 static codes, R9 illegal on 5/6
    for (int r = 0; r < 7; r++) begin
      rm_in = r[2:0];
      step();
      chk("R7 static rm", {29'h0, rm_eff}, r);
      chk("R9 illegal static", {31'h0, rm_illegal}, (r == 5 || r == 6) ? 1 : 0);
    end

    // R8 dynamic code uses bits 7:5 (currently 2)
    rm_in = 3'd7;
    step();
    chk("R8 dynamic rm", {29'h0, rm_eff}, 32'd2);
    chk("R9 legal dynamic", {31'h0, rm_illegal}, 32'd0);

    // R8 R9: dynamic 5 is illegal; written in same edge, old value used
    csr_we = 1'b1; csr_wdata = 32'h0000_00a0;
    step();
    csr_we = 1'b0;
    chk("R8 old dyn value at write edge", {29'h0, rm_eff}, 32'd2);
    step();
    chk("R8 dynamic rm 5", {29'h0, rm_eff}, 32'd5);
    chk("R9 dynamic illegal", {31'h0, rm_illegal}, 32'd1);

    // R9: effective 7 not flagged
    wr(32'h0000_00e0);
    step();
    chk("R8 dynamic rm 7", {29'h0, rm_eff}, 32'd7);
    chk("R9 code 7 legal", {31'h0, rm_illegal}, 32'd0);

    // R1 reset again after activity
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 rdata after rerun", csr_rdata, 32'h0);
    chk("R1 rm_eff after rerun", {29'h0, rm_eff}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule